// File: doc/BRIEF.md
# SRAM Bus Cycle Controller

This block turns single transfer requests from inside the chip into read and write cycles on an external asynchronous SRAM with a 16-bit data bus. A requester presents an address, write data, a read/write flag and a byte/halfword size, and raises a request. The controller then drives the address bus, chip enable, read strobe and two byte-lane write strobes. It returns a one-clock completion pulse together with the captured read data.

Cycle length has two parts. A 4-bit internal wait count is taken when the request is accepted. On top of that, an external active-low wait pin can hold the cycle open. The pin is sampled on the falling bus-clock edge, and only if the area is marked as SRAM and pin waiting is enabled.

Byte lanes are signalled in one of two ways. In address-bit mode, the lowest address line carries address bit 0 and the two write strobes pick the lanes. In byte-select mode, the lowest address line becomes an active-low byte-select strobe. The high write strobe becomes the other byte select, the low write strobe becomes a common write enable, and an endianness setting decides which data half each select covers.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, bus_ce_n_o, bus_rd_n_o, bus_wrh_n_o and bus_wrl_n_o are high, and done_o and bus_doe_o are low.
- R2: A request seen high at a rising edge while idle starts a cycle. bus_ce_n_o goes low from that edge for cfg_wait_i+2 clocks when no pin wait applies. done_o is then high for exactly one clock.
- R3: cfg_wait_i, the area and mode settings, and the request fields are captured at acceptance. Changing them during a cycle does not change that cycle.
- R4: The wait pin is sampled on the falling edge of each clock. The sample is used only in what would be the final clock, and each low sample there adds one clock. The pin is ignored unless both cfg_pin_wait_en_i and cfg_area_sram_i are 1, for writes as well as reads.
- R5: Pin waits add to the internal count. With cfg_wait_i=0 and two low samples, the cycle lasts 4 clocks.
- R6: During a read, bus_rd_n_o is low for the whole active period and bus_wrl_n_o stays high. rdata_o holds the value on bus_din_i at the rising edge that ends the cycle.
- R7: Lanes are decoded as follows. A halfword (req_byte_i=0) uses both lanes. A byte uses the low lane (bus bits 7:0) when address bit 0 is 0 in little endian (cfg_big_endian_i=0) or 1 in big endian; otherwise it uses the high lane (bits 15:8). In address-bit mode (cfg_bsl_mode_i=0), a write pulls bus_wrl_n_o low only for the low lane and bus_wrh_n_o only for the high lane, and bus_a_o[0] equals request address bit 0.
- R8: In byte-select mode (cfg_bsl_mode_i=1), bus_wrl_n_o is low for the active period of every write. bus_a_o[0] is the low-lane select in little endian and the high-lane select in big endian, and bus_wrh_n_o is the other lane's select. Both selects are active low, and they are driven for reads and for writes.
- R9: bus_a_o[23:1] equals request address bits 23:1 for the whole cycle. An SRAM with word lines wired to bus_a_o[9:1] therefore sees CPU bit 1 on its bit 0.
- R10: For a write, bus_doe_o is high and bus_dout_o equals the request data during every active clock. bus_doe_o is low outside the active period.
- R11: In the clock where done_o is high, all strobes are high. A request held through that clock is not taken until the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request, held until done_o |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_byte_i | input | 1 | 1 = byte access, 0 = halfword |
| req_addr_i | input | 24 | Byte address |
| req_wdata_i | input | 16 | Write data, already on its lane |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Captured read data |
| cfg_wait_i | input | 4 | Internal wait count |
| cfg_pin_wait_en_i | input | 1 | Enables the wait pin |
| cfg_area_sram_i | input | 1 | Area is configured as SRAM |
| cfg_bsl_mode_i | input | 1 | 0 = address-bit lanes, 1 = byte-select lanes |
| cfg_big_endian_i | input | 1 | Endianness for lane mapping |
| bus_a_o | output | 24 | Address bus; bit 0 doubles as low byte select |
| bus_ce_n_o | output | 1 | Chip enable, active low |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| bus_wrh_n_o | output | 1 | High write strobe or byte select, active low |
| bus_wrl_n_o | output | 1 | Low write strobe or write enable, active low |
| bus_dout_o | output | 16 | Write data to the bus |
| bus_doe_o | output | 1 | Data output enable |
| bus_din_i | input | 16 | Read data from the bus |
| bus_wait_n_i | input | 1 | External wait, active low |

## Verification
The checker watches several rules on every clock. The completion pulse lasts one clock, follows an active clock and finds every strobe released. The data drive stays inside chip enable, a read never asserts the write enable, and the word address holds while chip enable is low. Cycle lengths under combinations of internal count and pin waits, the ignored pin when disabled, lane and strobe patterns in both modes and endiannesses, read data capture, and configuration changes made in the middle of a cycle depend on the request. These only show up in the bench's scoreboard scenarios.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_DONE = 2'd2
  } cyc_state_e;

  typedef struct packed {
    logic lo;
    logic hi;
  } lane_sel_t;

  typedef struct packed {
    logic ce_n;
    logic rd_n;
    logic wrh_n;
    logic wrl_n;
    logic a0_pin;
  } strobe_t;

  // Data lanes touched by an access: lo = bits 7:0, hi = bits 15:8.
  function automatic lane_sel_t lanes_of(input logic byte_acc,
                                         input logic a0,
                                         input logic big);
    lane_sel_t l;
    if (!byte_acc) begin
      l.lo = 1'b1;
      l.hi = 1'b1;
    end else begin
      l.lo = big ? a0 : !a0;
      l.hi = !l.lo;
    end
    return l;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/sram_wait_sampler.sv
// Captures the external wait level in the middle of each bus clock.
module sram_wait_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_n_i,
  output logic wait_n_smp_o
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_n_smp_o <= 1'b1;
    end else begin
      wait_n_smp_o <= wait_n_i;
    end
  end

endmodule

// File: rtl/sram_strobe_map.sv
module sram_strobe_map
  import sram_bus_pkg::*;
(
  input  logic    act_i,
  input  logic    we_i,
  input  logic    byte_i,
  input  logic    a0_i,
  input  logic    bsl_i,
  input  logic    big_i,
  output strobe_t stb_o
);

  lane_sel_t ln;
  logic      sel_lo;
  logic      sel_hi;

  always_comb begin
    ln     = lanes_of(byte_i, a0_i, big_i);
    sel_lo = act_i && ln.lo;
    sel_hi = act_i && ln.hi;

    stb_o.ce_n = !act_i;
    stb_o.rd_n = !(act_i && !we_i);

    if (!bsl_i) begin
      // address-bit lanes: per-lane write strobes, bit 0 passes through
      stb_o.wrl_n  = !(sel_lo && we_i);
      stb_o.wrh_n  = !(sel_hi && we_i);
      stb_o.a0_pin = a0_i;
    end else begin
      // byte-select lanes: common write enable plus two selects
      stb_o.wrl_n = !(act_i && we_i);
      if (big_i) begin
        stb_o.a0_pin = !sel_hi;
        stb_o.wrh_n  = !sel_lo;
      end else begin
        stb_o.a0_pin = !sel_lo;
        stb_o.wrh_n  = !sel_hi;
      end
    end
  end

endmodule

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq
  import sram_bus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  input  logic              pin_en_i,
  input  logic              bsl_i,
  input  logic              big_i,
  input  logic              wait_n_smp_i,
  input  logic [DATA_W-1:0] din_i,
  output cyc_state_e        state_o,
  output logic              we_o,
  output logic              byte_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              bsl_o,
  output logic              big_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int CNT_W = WAIT_W + 1;

  cyc_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cap_en;
  logic              rd_cap_en;
  logic              pin_en_q;
  logic              stretch;

  assign stretch = pin_en_q && !wait_n_smp_i;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cap_en    = 1'b0;
    rd_cap_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          state_d = ST_ACT;
          cnt_d   = CNT_W'(wait_cfg_i) + CNT_W'(1);
          cap_en  = 1'b1;
        end
      end
      ST_ACT: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (!stretch) begin
          state_d   = ST_DONE;
          rd_cap_en = !we_o;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      we_o     <= 1'b0;
      byte_o   <= 1'b0;
      addr_o   <= '0;
      wdata_o  <= '0;
      bsl_o    <= 1'b0;
      big_o    <= 1'b0;
      pin_en_q <= 1'b0;
      rdata_o  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (cap_en) begin
        we_o     <= we_i;
        byte_o   <= byte_i;
        addr_o   <= addr_i;
        wdata_o  <= wdata_i;
        bsl_o    <= bsl_i;
        big_o    <= big_i;
        pin_en_q <= pin_en_i;
      end
      if (rd_cap_en) begin
        rdata_o <= din_i;
      end
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_bus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic              req_byte_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [15:0]       req_wdata_i,
  output logic              done_o,
  output logic [15:0]       rdata_o,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              cfg_pin_wait_en_i,
  input  logic              cfg_area_sram_i,
  input  logic              cfg_bsl_mode_i,
  input  logic              cfg_big_endian_i,
  output logic [ADDR_W-1:0] bus_a_o,
  output logic              bus_ce_n_o,
  output logic              bus_rd_n_o,
  output logic              bus_wrh_n_o,
  output logic              bus_wrl_n_o,
  output logic [15:0]       bus_dout_o,
  output logic              bus_doe_o,
  input  logic [15:0]       bus_din_i,
  input  logic              bus_wait_n_i
);

  logic              rst_n_s;
  logic              wait_n_smp;
  cyc_state_e        state;
  logic              cap_we;
  logic              cap_byte;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_wdata;
  logic              cap_bsl;
  logic              cap_big;
  logic              act;
  strobe_t           stb;

  sram_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  sram_wait_sampler i_wait (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .wait_n_i     (bus_wait_n_i),
    .wait_n_smp_o (wait_n_smp)
  );

  sram_cycle_seq #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) i_seq (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .req_i        (req_i),
    .we_i         (req_we_i),
    .byte_i       (req_byte_i),
    .addr_i       (req_addr_i),
    .wdata_i      (req_wdata_i),
    .wait_cfg_i   (cfg_wait_i),
    .pin_en_i     (cfg_pin_wait_en_i && cfg_area_sram_i),
    .bsl_i        (cfg_bsl_mode_i),
    .big_i        (cfg_big_endian_i),
    .wait_n_smp_i (wait_n_smp),
    .din_i        (bus_din_i),
    .state_o      (state),
    .we_o         (cap_we),
    .byte_o       (cap_byte),
    .addr_o       (cap_addr),
    .wdata_o      (cap_wdata),
    .bsl_o        (cap_bsl),
    .big_o        (cap_big),
    .rdata_o      (rdata_o)
  );

  assign act = (state == ST_ACT);

  sram_strobe_map i_map (
    .act_i  (act),
    .we_i   (cap_we),
    .byte_i (cap_byte),
    .a0_i   (cap_addr[0]),
    .bsl_i  (cap_bsl),
    .big_i  (cap_big),
    .stb_o  (stb)
  );

  assign bus_a_o     = {cap_addr[ADDR_W-1:1], stb.a0_pin};
  assign bus_ce_n_o  = stb.ce_n;
  assign bus_rd_n_o  = stb.rd_n;
  assign bus_wrh_n_o = stb.wrh_n;
  assign bus_wrl_n_o = stb.wrl_n;
  assign bus_dout_o  = cap_wdata;
  assign bus_doe_o   = act && cap_we;
  assign done_o      = (state == ST_DONE);

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_o,
  input logic [ADDR_W-1:0] bus_a_o,
  input logic              bus_ce_n_o,
  input logic              bus_rd_n_o,
  input logic              bus_wrh_n_o,
  input logic              bus_wrl_n_o,
  input logic              bus_doe_o
);

  a_r2_done_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r2_done_after_active: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(!bus_ce_n_o));

  a_r11_idle_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bus_ce_n_o && bus_rd_n_o && bus_wrh_n_o && bus_wrl_n_o && !bus_doe_o));

  a_r6_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n_o |-> (bus_wrl_n_o && !bus_doe_o && !bus_ce_n_o));

  a_r10_doe_inside_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe_o |-> (!bus_ce_n_o && !bus_wrl_n_o || !bus_ce_n_o && !bus_wrh_n_o));

  a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce_n_o && $past(!bus_ce_n_o)) |-> $stable(bus_a_o[ADDR_W-1:1]));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done_o      (done_o),
  .bus_a_o     (bus_a_o),
  .bus_ce_n_o  (bus_ce_n_o),
  .bus_rd_n_o  (bus_rd_n_o),
  .bus_wrh_n_o (bus_wrh_n_o),
  .bus_wrl_n_o (bus_wrl_n_o),
  .bus_doe_o   (bus_doe_o)
);

// File: tb/test_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module test_sram_cycle_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we, bytea;
  logic [23:0] addr;
  logic [15:0] wdata;
  logic        done;
  logic [15:0] rdata;
  logic [3:0]  cfg_wait;
  logic        pin_en, area_sram, bsl, big;
  logic [23:0] bus_a;
  logic        ce_n, rd_n, wrh_n, wrl_n, doe;
  logic [15:0] dout, din;
  logic        wait_n;

  always #2.5 clk = ~clk;

  sram_cycle_ctrl i_sram_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(we), .req_byte_i(bytea),
    .req_addr_i(addr), .req_wdata_i(wdata), .done_o(done), .rdata_o(rdata),
    .cfg_wait_i(cfg_wait), .cfg_pin_wait_en_i(pin_en), .cfg_area_sram_i(area_sram),
    .cfg_bsl_mode_i(bsl), .cfg_big_endian_i(big), .bus_a_o(bus_a), .bus_ce_n_o(ce_n),
    .bus_rd_n_o(rd_n), .bus_wrh_n_o(wrh_n), .bus_wrl_n_o(wrl_n), .bus_dout_o(dout),
    .bus_doe_o(doe), .bus_din_i(din), .bus_wait_n_i(wait_n)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // SRAM model: read data is a function of the word address
  assign din = ce_n ? 16'h0000 : (bus_a[16:1] ^ 16'h5A3C);

  // wait device: holds the pin low for the first pin_lim active clocks
  int pin_lim = 0;
  int cyc_i = 0;
  initial begin
    wait_n = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      if (!ce_n) cyc_i++; else cyc_i = 0;
      wait_n = ce_n || (cyc_i > pin_lim);
    end
  end

  typedef struct {
    int          len;
    logic        we;
    logic [23:0] addr;
    logic [15:0] wdata;
    logic [3:0]  stb;    // {rd_n, wrh_n, wrl_n, a0 line}
    string       ltag;
    string       stag;
  } exp_t;

  exp_t sb[$];

  // monitor
  int          act_n = 0;
  bit          stb_bad = 0, a_bad = 0, d_bad = 0;
  logic [3:0]  stb_seen = 4'h0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!ce_n && sb.size() != 0) begin
        act_n++;
        if ({rd_n, wrh_n, wrl_n, bus_a[0]} !== sb[0].stb) begin
          stb_bad  = 1;
          stb_seen = {rd_n, wrh_n, wrl_n, bus_a[0]};
        end
        if (bus_a[23:1] !== sb[0].addr[23:1]) a_bad = 1;
        if (doe !== sb[0].we || (sb[0].we && dout !== sb[0].wdata)) d_bad = 1;
      end
      if (done) begin
        if (sb.size() == 0) begin
          chk(0, "R11 unexpected cycle", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(act_n == e.len, e.ltag, act_n, e.len);
          chk(!stb_bad, e.stag, stb_seen, e.stb);
          chk(!a_bad, "R9 address", bus_a, e.addr);
          if (e.we) chk(!d_bad, "R10 write data", dout, e.wdata);
          else chk(rdata === (e.addr[16:1] ^ 16'h5A3C), "R6 read data", rdata, e.addr[16:1] ^ 16'h5A3C);
          chk(ce_n && rd_n && wrh_n && wrl_n && !doe, "R11 strobes in done",
              {ce_n, rd_n, wrh_n, wrl_n, doe}, 5'b11110);
        end
        act_n = 0; stb_bad = 0; a_bad = 0; d_bad = 0;
      end
    end
  end

  // driver: computes expectations from the requirements and runs one transfer
  task automatic xfer(input bit w, input logic [23:0] a, input logic [15:0] wd, input bit b,
                      input int cw, input int pw, input bit pe, input bit sr, input bit bs,
                      input bit bg, input int cw_late, input bit hold,
                      input string ltag, input string stag);
    exp_t e;
    bit lo, hi;
    if (!b) begin lo = 1; hi = 1; end
    else begin lo = bg ? a[0] : !a[0]; hi = !lo; end
    e.len = cw + 2 + ((pe && sr) ? pw : 0);
    e.we = w; e.addr = a; e.wdata = wd; e.ltag = ltag; e.stag = stag;
    if (!bs) e.stb = {w, !(w && hi), !(w && lo), a[0]};
    else if (bg) e.stb = {w, !lo, !w, !hi};
    else e.stb = {w, !hi, !w, !lo};
    sb.push_back(e);
    we = w; addr = a; wdata = wd; bytea = b; cfg_wait = 4'(cw);
    pin_en = pe; area_sram = sr; bsl = bs; big = bg;
    pin_lim = cw + 1 + pw;
    req = 1'b1;
    do @(negedge clk); while (ce_n);
    if (cw_late >= 0) begin
      cfg_wait = 4'(cw_late);
      addr = ~a;
      bsl = ~bs;
    end
    while (!done) @(negedge clk);
    if (hold) begin
      @(negedge clk);
      chk(ce_n === 1'b1, "R11 request held in done clock", ce_n, 1'b1);
    end
    req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req = 0; we = 0; bytea = 0; addr = '0; wdata = '0;
    cfg_wait = 0; pin_en = 0; area_sram = 0; bsl = 0; big = 0;
    repeat (3) @(negedge clk);
    chk(ce_n && rd_n && wrh_n && wrl_n, "R1 strobes in reset", {ce_n, rd_n, wrh_n, wrl_n}, 4'hF);
    chk(!done && !doe, "R1 done/doe in reset", {done, doe}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ce_n && !done, "R1 idle after reset", {ce_n, done}, 2'b10);

    // reads: internal and pin waits
    xfer(0, 24'h000124, 0, 0, 0, 0, 0, 1, 0, 0, -1, 0, "R2 basic length", "R6 read strobes");
    xfer(0, 24'h0003A2, 0, 0, 3, 0, 0, 1, 0, 0, -1, 0, "R2 internal wait", "R6 read strobes");
    xfer(0, 24'h000046, 0, 0, 0, 2, 1, 1, 0, 0, -1, 0, "R5 pin on zero count", "R6 read strobes");
    xfer(0, 24'h001F00, 0, 0, 2, 3, 1, 1, 0, 0, -1, 0, "R5 pin plus count", "R6 read strobes");
    xfer(0, 24'h0000F0, 0, 0, 1, 2, 0, 1, 0, 0, -1, 0, "R4 pin disabled", "R6 read strobes");
    xfer(0, 24'h0000F2, 0, 0, 1, 2, 1, 0, 0, 0, -1, 0, "R4 area not SRAM", "R6 read strobes");
    xfer(0, 24'h00FFFE, 0, 0, 15, 0, 0, 1, 0, 0, -1, 0, "R2 max count", "R6 read strobes");

    // writes in address-bit mode
    xfer(1, 24'h000200, 16'hBEEF, 0, 0, 0, 0, 1, 0, 0, -1, 0, "R2 write length", "R7 halfword");
    xfer(1, 24'h000210, 16'h00A1, 1, 1, 0, 0, 1, 0, 0, -1, 0, "R2 write length", "R7 LE even byte");
    xfer(1, 24'h000211, 16'hB200, 1, 0, 0, 0, 1, 0, 0, -1, 0, "R2 write length", "R7 LE odd byte");
    xfer(1, 24'h000220, 16'hC300, 1, 0, 0, 0, 1, 0, 1, -1, 0, "R2 write length", "R7 BE even byte");
    xfer(1, 24'h000232, 16'h1234, 0, 4, 1, 1, 1, 0, 0, -1, 0, "R4 pin on write", "R7 halfword");

    // byte-select mode
    xfer(1, 24'h000301, 16'h5500, 1, 0, 0, 0, 1, 1, 0, -1, 0, "R2 write length", "R8 LE write odd");
    xfer(0, 24'h000300, 0, 1, 0, 0, 0, 1, 1, 1, -1, 0, "R2 basic length", "R8 BE read even");
    xfer(1, 24'h000304, 16'h6677, 0, 1, 0, 0, 1, 1, 1, -1, 0, "R2 write length", "R8 BE halfword");
    xfer(0, 24'h000306, 0, 1, 0, 0, 0, 1, 1, 0, -1, 0, "R2 basic length", "R8 LE read even");

    // configuration and request changes mid-cycle, request held through done
    xfer(0, 24'h000410, 0, 0, 2, 0, 0, 1, 0, 0, 9, 0, "R3 count captured", "R3 mode captured");
    xfer(1, 24'h000420, 16'h0F0F, 0, 0, 0, 0, 1, 0, 0, -1, 1, "R2 write length", "R7 halfword");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11 all cycles completed", sb.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog R2", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule